// File: doc/BRIEF.md
# Configurable AND-OR Programmable Logic Array

This block evaluates a small set of Boolean functions through two programmable planes. The AND plane forms a fixed number of product terms. Each product is any conjunction of input literals, so it need not be a full minterm. The OR plane then sums chosen products onto each output, and one product may be shared by several outputs. For the same functions, this usually needs far fewer gates than a decoder that produces every minterm.

Both planes sit in configuration registers loaded through a simple write port. The outputs are purely combinational in the inputs and the stored programming. A synchronous reset restores a default programming. With the default sizes of 3 inputs, 4 products and 3 outputs, that programming realises three functions that share four products.

Top module: `pla_array`

## Requirements
- R1: `out_bits` follows `in_bits` combinationally. An input change shows at the output within the same clock cycle, with no clock edge between.
- R2: After reset, output bit 2 is 1 exactly for input codes 1, 2, 3 and 4. The input code is `in_bits` read as an unsigned number, with bit 0 as the least significant bit.
- R3: After reset, output bit 1 is 1 exactly for input codes 2, 6 and 7.
- R4: After reset, output bit 0 is 1 exactly for input codes 4, 6 and 7.
- R5: An AND-plane write with `cfg_sel`=0 replaces product `cfg_row` with `cfg_data[2*NI-1:0]`. The field `[2i+1:2i]` controls input i: 00 means the input is unused, 01 takes its true value, 10 takes its complement, and 11 forces the product to 0.
- R6: A product whose fields are all 00 evaluates to 1.
- R7: An OR-plane write with `cfg_sel`=1 replaces the links of output `cfg_row` with `cfg_data[NP-1:0]`. Bit j set connects product j. Each output is the OR of its linked products, and one product may drive several outputs.
- R8: An output with no linked products is 0 for every input code.
- R9: A configuration write alters the outputs only after the next rising clock edge, never in the cycle in which it is presented.
- R10: A write to a row index beyond the plane's size (for example, OR row 3 when NO=3) changes nothing.
- R11: While `cfg_we` is 0, activity on `cfg_sel`, `cfg_row` and `cfg_data` changes nothing.
- R12: A synchronous reset taken after reprogramming restores the default functions of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset that loads the default programming |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Plane select: 0 selects the AND plane, 1 selects the OR plane |
| cfg_row | input | RW | Product index (AND plane) or output index (OR plane) |
| cfg_data | input | DW | Row contents to be written |
| in_bits | input | NI | Function inputs |
| out_bits | output | NO | Function outputs |

## Verification
The bench builds the block with its default values NI=3, NP=4 and NO=3. These sizes make the full 8-code input space cheap to sweep after every reprogramming step. They also give a 2-bit row index that can name a fourth OR row, which does not exist. That spare index exercises the out-of-range write of R10 through the ordinary port. With these sizes, the products and outputs left idle by reprogramming show the blank-product case and the empty-output case directly at the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_SKIP = 2'b00,
    LIT_TRUE = 2'b01,
    LIT_COMP = 2'b10,
    LIT_KILL = 2'b11
  } lit_e;

  localparam logic CFG_SEL_AND = 1'b0;
  localparam logic CFG_SEL_OR  = 1'b1;

  // Contribution of one input literal to a product.
  function automatic logic lit_pass(input logic [1:0] code, input logic x);
    logic r;
    case (lit_e'(code))
      LIT_SKIP: r = 1'b1;
      LIT_TRUE: r = x;
      LIT_COMP: r = ~x;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Default literal of input i in product p (4 shared products).
  function automatic lit_e default_lit(input int p, input int i);
    lit_e r;
    r = LIT_SKIP;
    case (p)
      0: r = (i == 2) ? LIT_COMP : (i == 1) ? LIT_TRUE : (i == 0) ? LIT_COMP : LIT_SKIP;
      1: r = (i == 2) ? LIT_TRUE : (i == 1) ? LIT_COMP : (i == 0) ? LIT_COMP : LIT_SKIP;
      2: r = (i == 2) ? LIT_COMP : (i == 0) ? LIT_TRUE : LIT_SKIP;
      3: r = (i == 2) ? LIT_TRUE : (i == 1) ? LIT_TRUE : LIT_SKIP;
      default: r = LIT_SKIP;
    endcase
    return r;
  endfunction

  // Default link of product p to output o.
  function automatic logic default_link(input int o, input int p);
    logic r;
    case (o)
      2: r = (p == 0) || (p == 1) || (p == 2);
      1: r = (p == 0) || (p == 3);
      0: r = (p == 1) || (p == 3);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int NI = 3,
  parameter int NP = 4,
  parameter int RW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [RW-1:0]        wr_row,
  input  logic [2*NI-1:0]      wr_data,
  input  logic [NI-1:0]        in_bits,
  output logic [NP-1:0]        prod,
  output logic [NP*NI*2-1:0]   cells_flat
);

  localparam int CW = 2 * NI;

  logic [CW-1:0] row_q [NP];

  function automatic logic [CW-1:0] default_row(input int p);
    logic [CW-1:0] r;
    r = '0;
    for (int i = 0; i < NI; i++) r[2*i +: 2] = default_lit(p, i);
    return r;
  endfunction

  function automatic logic term_eval(input logic [CW-1:0] cells, input logic [NI-1:0] x);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < NI; i++) acc = acc & lit_pass(cells[2*i +: 2], x[i]);
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NP; p++) row_q[p] <= default_row(p);
    end else if (wr_en) begin
      for (int p = 0; p < NP; p++) begin
        if (wr_row == RW'(p)) row_q[p] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_term
    assign prod[p]                    = term_eval(row_q[p], in_bits);
    assign cells_flat[p*CW +: CW]     = row_q[p];
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
  import pla_pkg::*;
#(
  parameter int NP = 4,
  parameter int NO = 3,
  parameter int RW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [RW-1:0]      wr_row,
  input  logic [NP-1:0]      wr_data,
  input  logic [NP-1:0]      prod,
  output logic [NO-1:0]      sums,
  output logic [NO*NP-1:0]   links_flat
);

  logic [NP-1:0] link_q [NO];

  function automatic logic [NP-1:0] default_links(input int o);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) r[p] = default_link(o, p);
    return r;
  endfunction

  function automatic logic sum_eval(input logic [NP-1:0] links, input logic [NP-1:0] terms);
    return |(links & terms);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < NO; o++) link_q[o] <= default_links(o);
    end else if (wr_en) begin
      for (int o = 0; o < NO; o++) begin
        if (wr_row == RW'(o)) link_q[o] <= wr_data;
      end
    end
  end

  for (genvar o = 0; o < NO; o++) begin : g_sum
    assign sums[o]                   = sum_eval(link_q[o], prod);
    assign links_flat[o*NP +: NP]    = link_q[o];
  end

endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter  int NI = 3,
  parameter  int NP = 4,
  parameter  int NO = 3,
  localparam int ROWS = (NP > NO) ? NP : NO,
  localparam int RW = (ROWS > 2) ? $clog2(ROWS) : 1,
  localparam int DW = (2 * NI > NP) ? 2 * NI : NP
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [RW-1:0] cfg_row,
  input  logic [DW-1:0] cfg_data,
  input  logic [NI-1:0] in_bits,
  output logic [NO-1:0] out_bits
);

  // Named internal events and state, visible to the bound checker.
  logic                 and_wr;
  logic                 or_wr;
  logic [NP-1:0]        prod_vec;
  logic [NP*NI*2-1:0]   and_flat;
  logic [NO*NP-1:0]     or_flat;

  assign and_wr = cfg_we && (cfg_sel == CFG_SEL_AND);
  assign or_wr  = cfg_we && (cfg_sel == CFG_SEL_OR);

  pla_and_plane #(.NI(NI), .NP(NP), .RW(RW)) and_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (and_wr),
    .wr_row     (cfg_row),
    .wr_data    (cfg_data[2*NI-1:0]),
    .in_bits    (in_bits),
    .prod       (prod_vec),
    .cells_flat (and_flat)
  );

  pla_or_plane #(.NP(NP), .NO(NO), .RW(RW)) or_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (or_wr),
    .wr_row     (cfg_row),
    .wr_data    (cfg_data[NP-1:0]),
    .prod       (prod_vec),
    .sums       (out_bits),
    .links_flat (or_flat)
  );

endmodule

// File: rtl/pla_array_checker.sv
module pla_array_checker #(
  parameter int NI = 3,
  parameter int NP = 4,
  parameter int NO = 3,
  parameter int RW = 2,
  parameter int DW = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic               cfg_sel,
  input logic [RW-1:0]      cfg_row,
  input logic [DW-1:0]      cfg_data,
  input logic [NI-1:0]      in_bits,
  input logic [NO-1:0]      out_bits,
  input logic [NP-1:0]      prod_vec,
  input logic [NP*NI*2-1:0] and_flat,
  input logic [NO*NP-1:0]   or_flat
);

  localparam int CW = 2 * NI;

  logic [NP-1:0] kill_vec, blank_vec;
  logic [NO-1:0] empty_vec;
  logic          pristine;
  logic          exp_valid;
  logic [RW-1:0] exp_row;
  logic [CW-1:0] exp_cells;
  logic [CW-1:0] seen_cells;

  always_comb begin
    kill_vec  = '0;
    blank_vec = '0;
    for (int p = 0; p < NP; p++) begin
      blank_vec[p] = (and_flat[p*CW +: CW] == '0);
      for (int i = 0; i < NI; i++)
        if (and_flat[p*CW + 2*i +: 2] == 2'b11) kill_vec[p] = 1'b1;
    end
    for (int o = 0; o < NO; o++) empty_vec[o] = (or_flat[o*NP +: NP] == '0);
    seen_cells = '0;
    for (int p = 0; p < NP; p++)
      if (int'(exp_row) == p) seen_cells = and_flat[p*CW +: CW];
  end

  always_ff @(posedge clk) begin
    if (rst) pristine <= 1'b1;
    else if (cfg_we) pristine <= 1'b0;
    exp_valid <= !rst && cfg_we && !cfg_sel && (int'(cfg_row) < NP);
    exp_row   <= cfg_row;
    exp_cells <= cfg_data[CW-1:0];
  end

  assert_kill_code_zeroes_R5: assert property (@(posedge clk) disable iff (rst)
    (prod_vec & kill_vec) == '0);

  assert_blank_product_high_R6: assert property (@(posedge clk) disable iff (rst)
    (blank_vec & ~prod_vec) == '0);

  assert_unlinked_output_low_R8: assert property (@(posedge clk) disable iff (rst)
    (out_bits & empty_vec) == '0);

  assert_write_lands_next_edge_R9: assert property (@(posedge clk) disable iff (rst)
    exp_valid |-> (seen_cells == exp_cells));

  assert_or_row_overflow_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel && (int'(cfg_row) >= NO)) |=> $stable(or_flat));

  assert_idle_port_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(and_flat) && $stable(or_flat)));

  if (NI == 3 && NP == 4 && NO == 3) begin : g_default
    logic [2:0] ref_out;
    always_comb begin
      ref_out[2] = in_bits inside {3'd1, 3'd2, 3'd3, 3'd4};
      ref_out[1] = in_bits inside {3'd2, 3'd6, 3'd7};
      ref_out[0] = in_bits inside {3'd4, 3'd6, 3'd7};
    end
    // Covers R2, R3 and R4 until the first write.
    assert_default_functions_R2: assert property (@(posedge clk) disable iff (rst)
      pristine |-> (out_bits == ref_out));
  end

endmodule

bind pla_array pla_array_checker #(.NI(NI), .NP(NP), .NO(NO), .RW(RW), .DW(DW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .cfg_sel  (cfg_sel),
  .cfg_row  (cfg_row),
  .cfg_data (cfg_data),
  .in_bits  (in_bits),
  .out_bits (out_bits),
  .prod_vec (prod_vec),
  .and_flat (and_flat),
  .or_flat  (or_flat)
);

// File: tb/pla_array_tb.sv
`timescale 1ns/1ps
module pla_array_tb_top;

  localparam int NI = 3, NP = 4, NO = 3, RW = 2, DW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [RW-1:0] cfg_row = '0;
  logic [DW-1:0] cfg_data = '0;
  logic [NI-1:0] in_bits = '0;
  logic [NO-1:0] out_bits;

  always #2.5 clk = ~clk;

  pla_array dut_i (.*);

  typedef struct {
    logic [NO-1:0] exp;
    logic [NI-1:0] stim;
    string         tag;
  } item_t;

  item_t q[$];
  event  ev_sample;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;

  // Bench-side model of the programming.
  logic [2*NI-1:0] m_and [NP];
  logic [NP-1:0]   m_or  [NO];

  task automatic model_default();
    m_and[0] = 6'b10_01_10;
    m_and[1] = 6'b01_10_10;
    m_and[2] = 6'b10_00_01;
    m_and[3] = 6'b01_01_00;
    m_or[0]  = 4'b1010;
    m_or[1]  = 4'b1001;
    m_or[2]  = 4'b0111;
  endtask

  function automatic logic [NO-1:0] model_eval(input logic [NI-1:0] x);
    logic [NO-1:0] r;
    r = '0;
    for (int p = 0; p < NP; p++) begin
      bit t;
      t = 1;
      for (int i = 0; i < NI; i++) begin
        logic [1:0] c;
        c = m_and[p][2*i +: 2];
        if (c == 2'b11) t = 0;
        else if (c == 2'b01 && x[i] == 1'b0) t = 0;
        else if (c == 2'b10 && x[i] == 1'b1) t = 0;
      end
      for (int o = 0; o < NO; o++) if (t && m_or[o][p]) r[o] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [NO-1:0] spec_default(input logic [NI-1:0] x);
    int c;
    c = int'(x);
    return {(c >= 1 && c <= 4), (c == 2 || c >= 6), (c == 4 || c >= 6)};
  endfunction

  // Monitor: pops expected items and compares with the output.
  initial forever begin
    item_t it;
    @(ev_sample);
    it = q.pop_front();
    n_vec++;
    if (out_bits !== it.exp) begin
      n_bad++;
      $display("FAIL %s in=%0d actual=%b expected=%b", it.tag, it.stim, out_bits, it.exp);
    end
  end

  task automatic push_check(input logic [NO-1:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.stim = in_bits; it.tag = tag;
    q.push_back(it);
    -> ev_sample;
    #0.1;
  endtask

  task automatic drive(input logic [NI-1:0] x, input logic [NO-1:0] exp, input string tag);
    @(negedge clk);
    in_bits = x;
    #1;
    push_check(exp, tag);
  endtask

  task automatic sweep_model(input string tag);
    for (int c = 0; c < 8; c++) drive(NI'(c), model_eval(NI'(c)), tag);
  endtask

  task automatic cfg_write(input logic sel, input int row, input logic [DW-1:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_row = RW'(row); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 1'b0 && row < NP) m_and[row] = data[2*NI-1:0];
    if (sel == 1'b1 && row < NO) m_or[row] = data[NP-1:0];
  endtask

  initial begin
    model_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2, R3, R4: default functions after reset
    for (int c = 0; c < 8; c++) drive(NI'(c), spec_default(NI'(c)), "R2/R3/R4 default");

    // R1: input change shows without a clock edge
    @(negedge clk);
    in_bits = 3'd4; #0.5; push_check(3'b101, "R1 comb a");
    in_bits = 3'd6; #0.5; push_check(3'b011, "R1 comb b");

    // R9 and R6: blank P2, old value before edge, new after
    @(negedge clk);
    in_bits = 3'd0;
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_row = 2'd2; cfg_data = 6'b00_00_00;
    #1;
    push_check(3'b000, "R9 before edge");
    @(negedge clk);
    cfg_we = 1'b0;
    m_and[2] = 6'b00_00_00;
    #1;
    push_check(3'b100, "R9/R6 after edge");

    // R5: kill code on P3, then complemented-only P0
    cfg_write(1'b0, 3, 6'b01_01_11);
    drive(3'd7, 3'b100, "R5 kill");
    drive(3'd6, 3'b100, "R5 kill");
    cfg_write(1'b0, 0, 6'b00_10_00);
    sweep_model("R5 literal codes");

    // R7: P0 shared by outputs 0 and 1
    cfg_write(1'b1, 0, 6'b00_0001);
    sweep_model("R7 shared product");

    // R8: output 1 unlinked
    cfg_write(1'b1, 1, 6'b00_0000);
    for (int c = 0; c < 8; c++) drive(NI'(c), model_eval(NI'(c)), "R8 empty output");

    // R10: row 3 of the OR plane does not exist
    cfg_write(1'b1, 3, 6'b00_1111);
    sweep_model("R10 out of range");

    // R11: port activity without enable
    @(negedge clk);
    cfg_sel = 1'b0; cfg_row = 2'd1; cfg_data = 6'b11_11_11;
    @(negedge clk);
    cfg_sel = 1'b1; cfg_row = 2'd2; cfg_data = 6'b00_0000;
    sweep_model("R11 no enable");

    // R12: reset restores defaults
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_default();
    for (int c = 0; c < 8; c++) drive(NI'(c), spec_default(NI'(c)), "R12 reset reload");

    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule